// File: doc/BRIEF.md
# Fixed-Point RGB to YIQ Colour-Space Converter

This block turns a stream of 8-bit red, green and blue pixel components into one luminance value (Y) and two colour-difference values (I and Q). Each output channel is a dot product of the three components with a row of 16-bit fixed-point weights scaled by 2^16. A half-LSB constant (2^15) is added to each sum, and the sum is then shifted arithmetically right by 16 bits. This gives round-to-nearest, with ties rounded towards plus infinity.

Pixels enter and leave through valid/ready handshakes. The datapath has three register stages:
- the weight products;
- the signed sum with the rounding constant;
- the shift, fit to output width and output register.

With the sink always ready, one pixel is accepted and one is produced every cycle. When the sink holds back, the whole pipeline freezes and the input side is stalled in the same cycle.

Top module: `yiq_convert_pipe`

## Requirements
- R1: Y equals floor((19595*R + 38470*G + 7471*B + 32768) / 65536), clamped to 0..255 and presented as an unsigned 8-bit value.
- R2: I equals floor((39059*R - 18022*G - 21037*B + 32768) / 65536), presented as a 9-bit two's-complement value (saturated to that width).
- R3: Q equals floor((13894*R - 34275*G + 20382*B + 32768) / 65536), presented as a 9-bit two's-complement value (saturated to that width).
- R4: A grey pixel (R = G = B = v) produces Y = v, I = 0 and Q = 0.
- R5: A pixel accepted at a rising edge is visible at the outputs, with out_valid high, after the third rising edge counted from that accept edge when out_ready stays high. Back-to-back pixels are accepted every cycle while out_ready is high.
- R6: While out_valid is high and out_ready is low, in_ready is low. At the next edge out_valid stays high and out_y, out_i and out_q do not change.
- R7: Results leave in the order the pixels entered, each exactly once; none is lost or duplicated.
- R8: While rst_n is low (synchronous, active low) the pipeline empties. out_valid is low one edge later, and in_ready is high.
- R9: For any 8-bit inputs, I stays within -152..152 and Q within -133..133, so the output saturation never engages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source offers a pixel |
| in_ready | output | 1 | Converter takes the offered pixel at this edge |
| in_r | input | 8 | Red component, unsigned |
| in_g | input | 8 | Green component, unsigned |
| in_b | input | 8 | Blue component, unsigned |
| out_valid | output | 1 | Converted pixel present on the outputs |
| out_ready | input | 1 | Sink takes the presented result at this edge |
| out_y | output | 8 | Luminance, unsigned |
| out_i | output | 9 | In-phase chroma, two's complement |
| out_q | output | 9 | Quadrature chroma, two's complement |

## Verification
The range and no-saturation assertions depend on two things. The three weight rows must be the fixed ones above, and every component must be an unsigned 8-bit code. The port width guarantees the second, so the bench pushes full-scale primaries, their complements and greys to reach the extreme sums. The stall assertions assume nothing about the sink, so the stimulus drops out_ready at random on roughly a third of the cycles. It keeps an unaccepted pixel stable until in_ready takes it, and it inserts idle gaps, so that the pipeline runs full, partly empty and frozen.

// File: rtl/yiq_pkg.sv
package yiq_pkg;

  localparam int COEF_W = 16;
  localparam int FRAC_W = 16;
  localparam int CHAN_N = 3;
  localparam int HALF   = 1 << (FRAC_W - 1);

  // Row index: 0 = luma, 1 = in-phase, 2 = quadrature.
  // Column index: 0 = red, 1 = green, 2 = blue.
  localparam int ROW_LUMA  = 0;
  localparam int ROW_INPH  = 1;
  localparam int ROW_QUAD  = 2;

  typedef logic [COEF_W-1:0] coef_t;

  localparam coef_t COEF_MAG [CHAN_N][CHAN_N] = '{
    '{16'd19595, 16'd38470, 16'd7471},
    '{16'd39059, 16'd18022, 16'd21037},
    '{16'd13894, 16'd34275, 16'd20382}
  };

  // Bit k set: the product of column k is subtracted instead of added.
  localparam logic [CHAN_N-1:0] COEF_SUB [CHAN_N] = '{3'b000, 3'b110, 3'b010};

  function automatic int fit_range(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int sat_signed(input int v, input int w);
    return fit_range(v, -(1 << (w - 1)), (1 << (w - 1)) - 1);
  endfunction

  function automatic int sat_unsigned(input int v, input int w);
    return fit_range(v, 0, (1 << w) - 1);
  endfunction

endpackage

// File: rtl/yiq_row_mac.sv
module yiq_row_mac
  import yiq_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ROW   = 0,
  parameter int ACC_W = 27
) (
  input  logic                          clk,
  input  logic                          adv,
  input  logic [CHAN_N-1:0][PIX_W-1:0]  pix,
  output logic signed [ACC_W-1:0]       acc
);

  localparam int PROD_W = PIX_W + COEF_W;

  logic [PROD_W-1:0]        prod_d [CHAN_N];
  logic [PROD_W-1:0]        prod_q [CHAN_N];
  logic signed [ACC_W-1:0]  term   [CHAN_N];
  logic signed [ACC_W-1:0]  sum_d;

  // Stage 1: unsigned products of component and weight magnitude.
  always_comb begin
    for (int k = 0; k < CHAN_N; k++) begin
      prod_d[k] = PROD_W'(pix[k]) * PROD_W'(COEF_MAG[ROW][k]);
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int k = 0; k < CHAN_N; k++) begin
        prod_q[k] <= prod_d[k];
      end
    end
  end

  // Stage 2: signed sum, each product added or subtracted, plus half LSB.
  always_comb begin
    for (int k = 0; k < CHAN_N; k++) begin
      term[k] = $signed(ACC_W'(prod_q[k]));
    end
  end

  always_comb begin
    sum_d = ACC_W'(HALF);
    for (int k = 0; k < CHAN_N; k++) begin
      if (COEF_SUB[ROW][k]) sum_d = sum_d - term[k];
      else                  sum_d = sum_d + term[k];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) acc <= sum_d;
  end

endmodule

// File: rtl/yiq_out_stage.sv
module yiq_out_stage
  import yiq_pkg::*;
#(
  parameter int ACC_W = 27,
  parameter int Y_W   = 8,
  parameter int I_W   = 9,
  parameter int Q_W   = 9
) (
  input  logic                    clk,
  input  logic                    adv,
  input  logic signed [ACC_W-1:0] acc_y,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic signed [ACC_W-1:0] acc_q,
  output logic [Y_W-1:0]          y,
  output logic [I_W-1:0]          i,
  output logic [Q_W-1:0]          q,
  output logic                    sat_hit
);

  localparam int SH_W = ACC_W - FRAC_W;

  logic signed [ACC_W-1:0] shf_y, shf_i, shf_q;
  logic signed [SH_W-1:0]  sh_y, sh_i, sh_q;
  int                      raw_y, raw_i, raw_q;
  int                      fit_y, fit_i, fit_q;

  // Arithmetic shift keeps the sign of the chroma sums.
  assign shf_y = acc_y >>> FRAC_W;
  assign shf_i = acc_i >>> FRAC_W;
  assign shf_q = acc_q >>> FRAC_W;
  assign sh_y  = shf_y[SH_W-1:0];
  assign sh_i  = shf_i[SH_W-1:0];
  assign sh_q  = shf_q[SH_W-1:0];

  always_comb begin
    raw_y = int'(sh_y);
    raw_i = int'(sh_i);
    raw_q = int'(sh_q);
    fit_y = sat_unsigned(raw_y, Y_W);
    fit_i = sat_signed(raw_i, I_W);
    fit_q = sat_signed(raw_q, Q_W);
  end

  assign sat_hit = (fit_y != raw_y) || (fit_i != raw_i) || (fit_q != raw_q);

  always_ff @(posedge clk) begin
    if (adv) begin
      y <= fit_y[Y_W-1:0];
      i <= fit_i[I_W-1:0];
      q <= fit_q[Q_W-1:0];
    end
  end

endmodule

// File: rtl/yiq_flow_ctrl.sv
module yiq_flow_ctrl #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             adv,
  output logic [DEPTH-1:0] vld
);

  // The whole pipe moves unless a finished result is waiting on the sink.
  assign adv      = !vld[DEPTH-1] || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n)   vld <= '0;
    else if (adv) vld <= {vld[DEPTH-2:0], in_valid};
  end

endmodule

// File: rtl/yiq_convert_pipe.sv
module yiq_convert_pipe
  import yiq_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int Y_W   = 8,
  parameter int I_W   = 9,
  parameter int Q_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [Y_W-1:0]   out_y,
  output logic [I_W-1:0]   out_i,
  output logic [Q_W-1:0]   out_q
);

  localparam int DEPTH = 3;
  localparam int ACC_W = PIX_W + COEF_W + 3;

  logic [CHAN_N-1:0][PIX_W-1:0] pix;
  logic signed [ACC_W-1:0]      acc [CHAN_N];
  logic                         pipe_adv;
  logic [DEPTH-1:0]             stage_vld;
  logic                         sat_hit;

  assign pix[0] = in_r;
  assign pix[1] = in_g;
  assign pix[2] = in_b;

  yiq_flow_ctrl #(.DEPTH(DEPTH)) u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .adv       (pipe_adv),
    .vld       (stage_vld)
  );

  for (genvar row = 0; row < CHAN_N; row++) begin : g_row
    yiq_row_mac #(.PIX_W(PIX_W), .ROW(row), .ACC_W(ACC_W)) u_mac (
      .clk (clk),
      .adv (pipe_adv),
      .pix (pix),
      .acc (acc[row])
    );
  end

  yiq_out_stage #(.ACC_W(ACC_W), .Y_W(Y_W), .I_W(I_W), .Q_W(Q_W)) u_out (
    .clk     (clk),
    .adv     (pipe_adv),
    .acc_y   (acc[ROW_LUMA]),
    .acc_i   (acc[ROW_INPH]),
    .acc_q   (acc[ROW_QUAD]),
    .y       (out_y),
    .i       (out_i),
    .q       (out_q),
    .sat_hit (sat_hit)
  );

  assign out_valid = stage_vld[DEPTH-1];

endmodule

// File: rtl/yiq_convert_checker.sv
module yiq_convert_checker #(
  parameter int Y_W   = 8,
  parameter int I_W   = 9,
  parameter int Q_W   = 9,
  parameter int DEPTH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [Y_W-1:0]   out_y,
  input logic [I_W-1:0]   out_i,
  input logic [Q_W-1:0]   out_q,
  input logic             pipe_adv,
  input logic [DEPTH-1:0] stage_vld,
  input logic             sat_hit
);

  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !out_valid); // R8

  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_i) && $stable(out_q)); // R6

  AST_ENTRY_TRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> stage_vld[0]); // R5

  AST_MID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_adv && stage_vld[0] |=> stage_vld[1]); // R7

  AST_I_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_i) >= -152) && ($signed(out_i) <= 152)); // R9

  AST_Q_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_q) >= -133) && ($signed(out_q) <= 133)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stage_vld[1] |-> !sat_hit); // R9

endmodule

bind yiq_convert_pipe yiq_convert_checker #(
  .Y_W(Y_W), .I_W(I_W), .Q_W(Q_W), .DEPTH(DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_y     (out_y),
  .out_i     (out_i),
  .out_q     (out_q),
  .pipe_adv  (pipe_adv),
  .stage_vld (stage_vld),
  .sat_hit   (sat_hit)
);

// File: tb/test_yiq_convert_pipe.sv
module test_yiq_convert_pipe;

  logic       clk = 1'b0;
  logic       rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [7:0] in_r, in_g, in_b, out_y;
  logic [8:0] out_i, out_q;

  always #5 clk = ~clk;

  yiq_convert_pipe i_yiq_convert_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_y(out_y), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int exp_y[$], exp_i[$], exp_q[$], grey_v[$];
  bit stall_seen = 1'b0;
  logic [7:0] st_y;
  logic [8:0] st_i, st_q;

  // Rounded floor division done on a shifted-positive dividend.
  function automatic int model_chan(int kr, int kg, int kb, int r, int g, int b);
    int s = kr * r + kg * g + kb * b + 32768;
    return (s + 33554432) / 65536 - 512;
  endfunction

  function automatic int clip(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(input bit iv, input logic [7:0] r, input logic [7:0] g,
                      input logic [7:0] b, input bit ordy, output bit took, output bit ov);
    @(negedge clk);
    in_valid = iv; in_r = r; in_g = g; in_b = b; out_ready = ordy;
    #1;
    ov = out_valid;
    if (stall_seen) begin
      check(out_valid, "R6 valid held", int'(out_valid), 1);
      check(out_y == st_y && out_i == st_i && out_q == st_q, "R6 data held",
            int'(out_y), int'(st_y));
    end
    stall_seen = 1'b0;
    if (out_valid && !out_ready) begin
      check(!in_ready, "R6 in_ready low while stalled", int'(in_ready), 0);
      stall_seen = 1'b1; st_y = out_y; st_i = out_i; st_q = out_q;
    end
    if (out_valid && out_ready) begin
      if (exp_y.size() == 0) begin
        check(1'b0, "R7 output without input", 1, 0);
      end else begin
        int ey, ei, eq, gv, ai, aq;
        ey = exp_y.pop_front(); ei = exp_i.pop_front();
        eq = exp_q.pop_front(); gv = grey_v.pop_front();
        ai = int'($signed(out_i)); aq = int'($signed(out_q));
        check(int'(out_y) == ey, "R1 Y", int'(out_y), ey);
        check(ai == ei, "R2 I", ai, ei);
        check(aq == eq, "R3 Q", aq, eq);
        check(ai >= -152 && ai <= 152 && aq >= -133 && aq <= 133, "R9 chroma range", ai, aq);
        if (gv >= 0) check(int'(out_y) == gv && ai == 0 && aq == 0, "R4 grey", int'(out_y), gv);
      end
    end
    took = iv && in_ready;
    if (took) begin
      exp_y.push_back(clip(model_chan(19595, 38470, 7471, r, g, b), 0, 255));
      exp_i.push_back(clip(model_chan(39059, -18022, -21037, r, g, b), -256, 255));
      exp_q.push_back(clip(model_chan(13894, -34275, 20382, r, g, b), -256, 255));
      grey_v.push_back((r == g && g == b) ? int'(r) : -1);
    end
  endtask

  task automatic send(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                      input int rdy_pct);
    bit took = 1'b0;
    bit ov;
    while (!took) step(1'b1, r, g, b, ($urandom % 100) < rdy_pct, took, ov);
  endtask

  task automatic idle(input int n, input bit rdy);
    bit took, ov;
    repeat (n) step(1'b0, 8'd0, 8'd0, 8'd0, rdy, took, ov);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit took, ov;
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_r = '0; in_g = '0; in_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R8 out_valid low in reset", int'(out_valid), 0);
    check(in_ready, "R8 in_ready high in reset", int'(in_ready), 1);
    rst_n = 1'b1;

    // Directed corners: black, white, primaries, complements, greys.
    send(8'd0, 8'd0, 8'd0, 100);       send(8'd255, 8'd255, 8'd255, 100);
    send(8'd255, 8'd0, 8'd0, 100);     send(8'd0, 8'd255, 8'd0, 100);
    send(8'd0, 8'd0, 8'd255, 100);     send(8'd0, 8'd255, 8'd255, 100);
    send(8'd255, 8'd0, 8'd255, 100);   send(8'd255, 8'd255, 8'd0, 100);
    send(8'd1, 8'd1, 8'd1, 100);       send(8'd128, 8'd128, 8'd128, 100);
    send(8'd254, 8'd254, 8'd254, 100); send(8'd100, 8'd50, 8'd200, 100);
    idle(5, 1'b1);

    // R5 latency: accept into an empty pipe, result after the third edge.
    step(1'b1, 8'd200, 8'd10, 8'd30, 1'b1, took, ov);
    check(took, "R5 accept into empty pipe", int'(took), 1);
    step(1'b0, 8'd0, 8'd0, 8'd0, 1'b1, took, ov);
    check(!ov, "R5 not yet valid after edge 1", int'(ov), 0);
    step(1'b0, 8'd0, 8'd0, 8'd0, 1'b1, took, ov);
    check(!ov, "R5 not yet valid after edge 2", int'(ov), 0);
    step(1'b0, 8'd0, 8'd0, 8'd0, 1'b1, took, ov);
    check(ov, "R5 valid after edge 3", int'(ov), 1);

    // R5 throughput: back-to-back accepts while the sink is ready.
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 8'(k * 31), 8'(255 - k * 17), 8'(k * 9), 1'b1, took, ov);
      check(took, "R5 back-to-back accept", int'(took), 1);
    end
    idle(5, 1'b1);

    // Random traffic with back-pressure and gaps.
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] r, g, b;
      r = 8'($urandom); g = 8'($urandom); b = 8'($urandom);
      if (($urandom % 10) == 0) begin
        r = ($urandom % 2) ? 8'd255 : 8'd0;
        g = ($urandom % 2) ? 8'd255 : 8'd0;
        b = ($urandom % 2) ? 8'd255 : 8'd0;
      end
      if (($urandom % 12) == 0) begin g = r; b = r; end
      send(r, g, b, 70);
      if (($urandom % 5) == 0) idle(1, ($urandom % 2) == 1);
    end
    idle(8, 1'b1);
    check(exp_y.size() == 0, "R7 every pixel delivered", exp_y.size(), 0);

    // R8 mid-stream reset drops pixels in flight.
    step(1'b1, 8'd40, 8'd80, 8'd120, 1'b0, took, ov);
    step(1'b1, 8'd90, 8'd20, 8'd10, 1'b0, took, ov);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid, "R8 pipeline emptied by reset", int'(out_valid), 0);
    exp_y.delete(); exp_i.delete(); exp_q.delete(); grey_v.delete();
    stall_seen = 1'b0;
    rst_n = 1'b1;
    idle(4, 1'b1);
    check(exp_y.size() == 0, "R8 nothing emerges after reset", exp_y.size(), 0);
    send(8'd60, 8'd60, 8'd60, 100);
    idle(5, 1'b1);
    check(exp_y.size() == 0, "R7 recovery pixel delivered", exp_y.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule